// File: doc/BRIEF.md
# Up/Continuous Timer with Reset/Set PWM Channels

This block is a 16-bit timer peripheral driven through a small register port. Its count advances on one of two tick enables: a slow auxiliary tick or a fast subsystem tick. A control field picks one of these sources. A second control field picks up-counting, free-running (continuous) counting, or halt. In up mode the count climbs from zero to the period register and then returns to zero. In continuous mode it runs through the full 16-bit range and wraps.

Each compare channel drives one PWM output in reset/set fashion, and all channels share the single period. The output goes high when a period ends and low when the count reaches that channel's compare value. The period event has its own flag and interrupt line. The channel compare events and the timer overflow are collected in a vector register. A read of that register returns an even code for the most urgent pending source and clears only that source.

The counter is a three-state machine: HALT, UP and FREE. Every control write makes a transition from the current state, chosen by the mode field. Mode 1 takes go_up into UP. Mode 2 takes go_free into FREE. Mode 0 or 3 takes go_halt into HALT. A control write with the same mode keeps the state.

Top module: `ut_timer`

## Requirements
- R1: After reset the count is 0, the state is HALT, every PWM output is low, `period_irq` and `vec_irq` are low, and both the control register and the vector register read 0.
- R2: Register addresses are: 0 control, 1 count (read only), 2 period, 3+k compare value of channel k (k from 0), 9 status, 10 vector. `rdata` shows the addressed register in the same cycle. A write takes effect at the clock edge on which `wr_en` is high.
- R3: Control bits [1:0] select the tick source. Value 1 uses `slow_tick` and value 2 uses `fast_tick`. Values 0 and 3 give no tick, and the count holds.
- R4: Control bits [3:2] select the mode: 1 up, 2 continuous, 0 or 3 halt. In halt the count holds its value.
- R5: In up mode, each tick moves the count from P (the period register) to 0 and from any other value v to v+1. The sequence is 0,1,…,P,0, so one period lasts P+1 ticks.
- R6: In continuous mode the count runs to 0xFFFF and wraps to 0, whatever the period register holds.
- R7: Writing control with bit 5 set forces the count to 0 at that edge. The other control fields are written at the same edge.
- R8: A tick taken while the count equals P sets the period flag. The flag shows as status bit 0 and on `period_irq`. Writing status with bit 0 set clears the flag.
- R9: In up mode, channel k goes high on the tick that ends count P and goes low on the tick whose next count equals its compare value C. It is high for C of every P+1 ticks.
- R10: In up mode, a channel with C = 0 stays low, because the low event wins over the high event on the same tick. A channel with C > P stays high.
- R11: A tick whose next count equals channel k's compare value sets that channel's flag. The vector register reports channel k as code 2(k+1) and the overflow as code 14. It reads 0 when nothing is pending, and `vec_irq` is high while anything is pending.
- R12: The vector register reports the lowest-numbered pending channel first and the overflow last. The read clears only the source it reports.
- R13: The continuous-mode wrap sets the overflow flag only when control bit 4 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| slow_tick | input | 1 | Auxiliary tick enable |
| fast_tick | input | 1 | Subsystem tick enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Read strobe; with address 10 it acknowledges the vector |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the addressed register |
| pwm_out | output | NCH | One reset/set PWM output per channel |
| period_irq | output | 1 | Period flag |
| vec_irq | output | 1 | Any vector source pending |

## Verification
A write is registered at the edge where `wr_en` is high, and the state change it causes takes effect there. The first tick in the new mode is therefore taken one edge later. The count, flags and PWM outputs change on the tick edge, and `rdata` follows them in the same cycle with no added register. The bench drives each access between edges and samples one nanosecond after the falling edge, so each expected count is the number of tick edges since the write. A vector read clears its source at the edge that ends the read. PWM duty is measured as high cycles over one full period, taken only after two full periods have passed, so the result does not depend on where the window starts.

// File: rtl/ut_pkg.sv
package ut_pkg;

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_UP   = 2'd1,
        ST_FREE = 2'd2
    } run_state_e;

    localparam logic [3:0] RA_CTRL   = 4'd0;
    localparam logic [3:0] RA_COUNT  = 4'd1;
    localparam logic [3:0] RA_PERIOD = 4'd2;
    localparam logic [3:0] RA_CMP0   = 4'd3;
    localparam logic [3:0] RA_STAT   = 4'd9;
    localparam logic [3:0] RA_VEC    = 4'd10;

    localparam int CB_OVF_IE = 4;
    localparam int CB_CLEAR  = 5;

    localparam logic [1:0] SRC_SLOW = 2'd1;
    localparam logic [1:0] SRC_FAST = 2'd2;

    localparam logic [3:0] CODE_OVF = 4'd14;

    // Source index below nch is a channel; index nch is the overflow.
    function automatic logic [3:0] vec_code(input int idx, input int nch);
        if (idx >= nch) return CODE_OVF;
        return 4'(2 * (idx + 1));
    endfunction

endpackage

// File: rtl/ut_counter.sv
module ut_counter
    import ut_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         mode_wr_i,
    input  logic [1:0]   mode_i,
    input  logic         clr_i,
    input  logic [W-1:0] period_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] cnt_next_o,
    output logic         adv_o,
    output logic         per_hit_o,
    output logic         ovf_o,
    output run_state_e   state_o
);

    localparam logic [W-1:0] CNT_MAX = '1;

    run_state_e   state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d;
    logic         adv;

    // State register: transitions happen only on a control write.
    always_comb begin
        state_d = state_q;
        if (mode_wr_i) begin
            unique case (mode_i)
                2'd1:    state_d = ST_UP;
                2'd2:    state_d = ST_FREE;
                default: state_d = ST_HALT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // Outputs of the state machine: next count and events.
    always_comb begin
        adv = tick_i && (state_q != ST_HALT) && !clr_i;
        unique case (state_q)
            ST_UP:   cnt_d = (cnt_q == period_i) ? '0 : cnt_q + W'(1);
            ST_FREE: cnt_d = cnt_q + W'(1);
            default: cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr_i) cnt_q <= '0;
        else if (adv)   cnt_q <= cnt_d;
    end

    assign cnt_o      = cnt_q;
    assign cnt_next_o = cnt_d;
    assign adv_o      = adv;
    assign per_hit_o  = adv && (cnt_q == period_i);
    assign ovf_o      = adv && (state_q == ST_FREE) && (cnt_q == CNT_MAX);
    assign state_o    = state_q;

    // R5
    up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && state_q == ST_UP && cnt_q == period_i) |=> (cnt_q == '0));

    // R4
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !clr_i) |=> (cnt_q == $past(cnt_q)));

    // R6
    free_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && state_q == ST_FREE && cnt_q == CNT_MAX) |=> (cnt_q == '0));

endmodule

// File: rtl/ut_pwm_ch.sv
module ut_pwm_ch #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv_i,
    input  logic         up_i,
    input  logic         per_hit_i,
    input  logic [W-1:0] cnt_next_i,
    input  logic [W-1:0] cmp_i,
    output logic         pwm_o,
    output logic         cmp_hit_o
);

    logic cmp_hit;
    logic pwm_q;

    assign cmp_hit = adv_i && (cnt_next_i == cmp_i);

    // Reset (low) has priority over set (high) on the same tick.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         pwm_q <= 1'b0;
        else if (cmp_hit)   pwm_q <= 1'b0;
        else if (per_hit_i) pwm_q <= 1'b1;
    end

    assign pwm_o     = pwm_q;
    assign cmp_hit_o = cmp_hit;

    // R10
    zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_i && per_hit_i && cmp_i == '0) |=> !pwm_o);

endmodule

// File: rtl/ut_irq_vec.sv
module ut_irq_vec
    import ut_pkg::*;
#(
    parameter int NCH = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [NCH:0] set_i,
    input  logic         ack_i,
    output logic [3:0]   code_o,
    output logic         pend_o
);

    logic [NCH:0] flag_q;
    logic [NCH:0] clr_mask;
    logic         hit;
    int           sel;

    // Scan from the overflow down so the lowest index is kept.
    always_comb begin
        hit = 1'b0;
        sel = 0;
        for (int i = NCH; i >= 0; i--) begin
            if (flag_q[i]) begin
                hit = 1'b1;
                sel = i;
            end
        end
        clr_mask = '0;
        if (ack_i && hit) clr_mask[sel] = 1'b1;
        code_o = hit ? vec_code(sel, NCH) : 4'd0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr_mask) | set_i;
    end

    assign pend_o = hit;

    // R12
    vec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && pend_o && set_i == '0)
            |=> ($countones(flag_q) == $past($countones(flag_q)) - 1));

    // R11
    vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_o && set_i == '0) |=> (code_o == 4'd0));

endmodule

// File: rtl/ut_timer.sv
module ut_timer
    import ut_pkg::*;
#(
    parameter int W   = 16,
    parameter int NCH = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           slow_tick,
    input  logic           fast_tick,
    input  logic           wr_en,
    input  logic           rd_en,
    input  logic [3:0]     addr,
    input  logic [W-1:0]   wdata,
    output logic [W-1:0]   rdata,
    output logic [NCH-1:0] pwm_out,
    output logic           period_irq,
    output logic           vec_irq
);

    localparam int PAD = W - 6;

    logic [1:0]   src_q;
    logic         ovf_ie_q;
    logic [W-1:0] period_q;
    logic [W-1:0] cmp_q [NCH];
    logic         per_flag_q;

    logic         ctrl_wr, stat_wr, vec_ack, tick;
    logic [W-1:0] cnt, cnt_next;
    logic         adv, per_hit, ovf;
    run_state_e   state;
    logic [NCH-1:0] cmp_hit;
    logic [NCH:0]   src_set;
    logic [3:0]     vcode;

    assign ctrl_wr = wr_en && (addr == RA_CTRL);
    assign stat_wr = wr_en && (addr == RA_STAT);
    assign vec_ack = rd_en && (addr == RA_VEC);

    always_comb begin
        case (src_q)
            SRC_SLOW: tick = slow_tick;
            SRC_FAST: tick = fast_tick;
            default:  tick = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q    <= '0;
            ovf_ie_q <= 1'b0;
            period_q <= '0;
            for (int k = 0; k < NCH; k++) cmp_q[k] <= '0;
        end else if (wr_en) begin
            if (addr == RA_CTRL) begin
                src_q    <= wdata[1:0];
                ovf_ie_q <= wdata[CB_OVF_IE];
            end
            if (addr == RA_PERIOD) period_q <= wdata;
            for (int k = 0; k < NCH; k++)
                if (addr == RA_CMP0 + 4'(k)) cmp_q[k] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) per_flag_q <= 1'b0;
        else        per_flag_q <= per_hit | (per_flag_q & ~(stat_wr & wdata[0]));
    end

    ut_counter #(.W(W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .mode_wr_i  (ctrl_wr),
        .mode_i     (wdata[3:2]),
        .clr_i      (ctrl_wr & wdata[CB_CLEAR]),
        .period_i   (period_q),
        .cnt_o      (cnt),
        .cnt_next_o (cnt_next),
        .adv_o      (adv),
        .per_hit_o  (per_hit),
        .ovf_o      (ovf),
        .state_o    (state)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        ut_pwm_ch #(.W(W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .adv_i      (adv),
            .up_i       (state == ST_UP),
            .per_hit_i  (per_hit),
            .cnt_next_i (cnt_next),
            .cmp_i      (cmp_q[g]),
            .pwm_o      (pwm_out[g]),
            .cmp_hit_o  (cmp_hit[g])
        );
    end

    assign src_set = {ovf & ovf_ie_q, cmp_hit};

    ut_irq_vec #(.NCH(NCH)) u_vec (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (src_set),
        .ack_i  (vec_ack),
        .code_o (vcode),
        .pend_o (vec_irq)
    );

    always_comb begin
        rdata = '0;
        case (addr)
            RA_CTRL:   rdata = {{PAD{1'b0}}, 1'b0, ovf_ie_q, 2'(state), src_q};
            RA_COUNT:  rdata = cnt;
            RA_PERIOD: rdata = period_q;
            RA_STAT:   rdata = {{(W-1){1'b0}}, per_flag_q};
            RA_VEC:    rdata = {{(W-4){1'b0}}, vcode};
            default: begin
                for (int k = 0; k < NCH; k++)
                    if (addr == RA_CMP0 + 4'(k)) rdata = cmp_q[k];
            end
        endcase
    end

    assign period_irq = per_flag_q;

    // R8
    per_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_hit |=> period_irq);

endmodule

// File: tb/sim_ut_timer.sv
module sim_ut_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        fast_tick = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [5:0]  pwm_out;
    logic        period_irq, vec_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ut_timer u0 (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .pwm_out(pwm_out), .period_irq(period_irq), .vec_irq(vec_irq)
    );

    // period, cmp0, cmp1, expected high cycles ch0, ch1 (R9, R10)
    localparam logic [15:0] TAB [6][5] = '{
        '{16'd511, 16'd384, 16'd128, 16'd384, 16'd128},
        '{16'd9,   16'd3,   16'd7,   16'd3,   16'd7},
        '{16'd9,   16'd0,   16'd10,  16'd0,   16'd10},
        '{16'd9,   16'd9,   16'd1,   16'd9,   16'd1},
        '{16'd0,   16'd0,   16'd1,   16'd0,   16'd1},
        '{16'd63,  16'd32,  16'd64,  16'd32,  16'd64}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [15:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic rd_vec(output logic [15:0] v);
        @(negedge clk);
        addr = 4'd10; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic drain(output int n14);
        logic [15:0] v;
        n14 = 0;
        for (int i = 0; i < 12; i++) begin
            rd_vec(v);
            if (v == 16'd14) n14++;
            if (v == 16'd0) break;
        end
    endtask

    initial begin
        forever begin
            repeat (3) @(negedge clk) slow_tick = 1'b0;
            @(negedge clk) slow_tick = 1'b1;
        end
    end

    initial begin
        repeat (199000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        summary();
    end

    initial begin
        logic [15:0] v, c1;
        int n14, h0, h1, p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        peek(4'd1, v); chk(v == 0, "R1 count", v, 0);
        peek(4'd0, v); chk(v == 0, "R1 ctrl", v, 0);
        peek(4'd10, v); chk(v == 0, "R1 vector", v, 0);
        chk(pwm_out == 0 && !period_irq && !vec_irq, "R1 outputs",
            {pwm_out, period_irq, vec_irq}, 0);

        // R2/R5: exact up-mode count sequence with period 4, fast source
        wr(4'd2, 16'd4);
        peek(4'd2, v); chk(v == 4, "R2 period readback", v, 4);
        wr(4'd0, 16'h0006);
        peek(4'd1, v); chk(v == 0, "R5 first count", v, 0);
        for (int k = 1; k < 12; k++) begin
            @(negedge clk);
            peek(4'd1, v); chk(v == 16'(k % 5), "R5 count seq", v, k % 5);
        end

        // R4: halt holds count, mode 3 also halts
        wr(4'd0, 16'h0000);
        peek(4'd1, c1);
        repeat (15) @(negedge clk);
        peek(4'd1, v); chk(v == c1, "R4 halt", v, c1);
        wr(4'd0, 16'h000E);
        peek(4'd1, c1);
        repeat (10) @(negedge clk);
        peek(4'd1, v); chk(v == c1, "R4 mode3", v, c1);

        // R8: period flag timing and clear
        wr(4'd0, 16'h0020);
        wr(4'd9, 16'h0001);
        wr(4'd0, 16'h0006);
        repeat (4) @(negedge clk);
        peek(4'd9, v); chk(v == 0 && !period_irq, "R8 before wrap", v, 0);
        @(negedge clk);
        peek(4'd9, v); chk(v == 1 && period_irq, "R8 at wrap", v, 1);
        wr(4'd0, 16'h0000);
        wr(4'd9, 16'h0001);
        peek(4'd9, v); chk(v == 0 && !period_irq, "R8 cleared", v, 0);

        // R3: slow source advances once per 4 clocks, source 0 holds
        wr(4'd0, 16'h0020);
        wr(4'd2, 16'd1000);
        wr(4'd0, 16'h0005);
        repeat (40) @(negedge clk);
        peek(4'd1, v); chk(v == 10, "R3 slow source", v, 10);
        wr(4'd0, 16'h0004);
        peek(4'd1, c1);
        repeat (20) @(negedge clk);
        peek(4'd1, v); chk(v == c1, "R3 no source", v, c1);

        // R7: clear while running
        wr(4'd0, 16'h0006);
        repeat (30) @(negedge clk);
        wr(4'd0, 16'h0026);
        peek(4'd1, v); chk(v == 0, "R7 clear", v, 0);

        // R9/R10: duty vector table
        for (int t = 0; t < 6; t++) begin
            p = int'(TAB[t][0]);
            wr(4'd0, 16'h0020);
            wr(4'd2, TAB[t][0]);
            wr(4'd3, TAB[t][1]);
            wr(4'd4, TAB[t][2]);
            wr(4'd0, 16'h0006);
            repeat (2 * (p + 1) + 4) @(negedge clk);
            h0 = 0; h1 = 0;
            for (int c = 0; c < p + 1; c++) begin
                @(negedge clk);
                if (pwm_out[0]) h0++;
                if (pwm_out[1]) h1++;
            end
            chk(h0 == int'(TAB[t][3]), "R9/R10 ch0 duty", h0, int'(TAB[t][3]));
            chk(h1 == int'(TAB[t][4]), "R9/R10 ch1 duty", h1, int'(TAB[t][4]));
        end

        // R11/R12: priority among channel flags
        wr(4'd0, 16'h0020);
        drain(n14);
        wr(4'd2, 16'd20);
        wr(4'd3, 16'd5);
        wr(4'd4, 16'd3);
        wr(4'd0, 16'h0006);
        repeat (10) @(negedge clk);
        wr(4'd0, 16'h0000);
        chk(vec_irq, "R11 vec_irq pending", vec_irq, 1);
        rd_vec(v); chk(v == 2, "R12 first code", v, 2);
        rd_vec(v); chk(v == 4, "R12 second code", v, 4);
        rd_vec(v); chk(v == 0, "R11 empty", v, 0);
        chk(!vec_irq, "R11 vec_irq idle", vec_irq, 0);

        // R6/R13: continuous wrap without overflow enable
        wr(4'd0, 16'h0020);
        wr(4'd2, 16'd100);
        wr(4'd0, 16'h000A);
        repeat (65546) @(negedge clk);
        peek(4'd1, v); chk(v == 10, "R6 wrap count", v, 10);
        wr(4'd0, 16'h0000);
        drain(n14);
        chk(n14 == 0, "R13 no overflow when disabled", n14, 0);

        // R13/R12: overflow enabled, full priority sequence
        wr(4'd0, 16'h001A);
        repeat (65540) @(negedge clk);
        wr(4'd0, 16'h0010);
        for (int k = 1; k <= 6; k++) begin
            rd_vec(v); chk(v == 16'(2 * k), "R12 channel code", v, 2 * k);
        end
        rd_vec(v); chk(v == 14, "R13 overflow code", v, 14);
        rd_vec(v); chk(v == 0, "R11 drained", v, 0);

        summary();
    end

endmodule